// File: doc/BRIEF.md
# Precision-Time Event Frame Classifier

The block watches receive frames as they stream past, one byte per beat, and decides for each frame whether it carries a precision-time-protocol event message that should trigger a timestamp capture. It parses untagged Ethernet frames at fixed byte offsets. It recognises event messages carried directly over Ethernet, which it identifies by EtherType. It also recognises event messages carried over UDP in IPv4, which it identifies by IP protocol and UDP port.

A small capture-mode input selects the rule set. The modes are: capture nothing; version-1 Sync over UDP; version-1 Delay_Req over UDP; version-2 events over either Ethernet or UDP; and capture every frame. An optional source-port check tightens the UDP match. At most one capture pulse is produced per frame, in the cycle right after the frame's last byte.

Top module: `ptp_evt_classifier`

## Requirements
- R1: While reset is held and after it is released with no traffic, `capture_o` is low.
- R2: `capture_o` is a one-cycle pulse that is high exactly in the cycle after a beat with `valid_i` and `eof_i` both high, and only when that frame qualifies under the mode present on that last beat.
- R3: Mode code 0, and the unused codes 5, 6 and 7, never produce a capture.
- R4: Mode code 4 captures every frame, whatever its content and length, including a one-byte frame.
- R5: In mode code 3, a frame qualifies on the Ethernet path when bytes 12 and 13 are 0x88 and 0xF7 and the low nibble of byte 14 is 0 to 3. Any other nibble or EtherType does not qualify on this path.
- R6: A frame passes the UDP match when bytes 12 and 13 are 0x08 and 0x00, byte 23 is 17, and bytes 36 and 37 hold 319 big-endian (0x01, 0x3F). In mode code 3 it then qualifies if the low nibble of byte 42 is 0 to 3.
- R7: When `src_chk_i` is high, the UDP match also requires bytes 34 and 35 to hold 319 big-endian. When `src_chk_i` is low, those bytes are not examined.
- R8: Mode code 1 qualifies UDP-matched frames whose byte 74 is 0. Mode code 2 qualifies UDP-matched frames whose byte 74 is 1. Ethernet-path frames never qualify in these modes.
- R9: A frame that ends before the last byte its rule examines does not qualify, except in mode code 4. The minimum lengths are 15 bytes for the Ethernet path, 43 bytes for version-2 over UDP, and 75 bytes for version-1.
- R10: A beat with `sof_i` high restarts parsing at byte 0, so an aborted frame's bytes do not affect the next frame. Beats with `valid_i` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Frame byte, first byte = destination address MSB |
| valid_i | input | 1 | Byte on `data_i` is valid this cycle |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Marks the last byte of a frame |
| mode_i | input | 3 | Capture mode: 0 off, 1 v1 Sync, 2 v1 Delay_Req, 3 v2 events, 4 all |
| src_chk_i | input | 1 | Also require UDP source port 319 |
| capture_o | output | 1 | Timestamp capture pulse |

## Verification
The only result is the capture pulse, and it is due exactly one clock after the beat that carries the end-of-frame marker. There is one register between that beat and the port. The bench computes each frame's verdict from the bytes it sends and the mode held on the last byte. It delays that verdict through one clock edge of its own. It then compares the port against the delayed verdict at every falling edge, so a pulse that comes early, late, twice or never is caught in the cycle it goes wrong. Idle gaps, back-to-back frames and aborted frames change only when the final beat arrives, so the same one-cycle rule covers them.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;
  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_V1_SYNC = 3'd1,
    MODE_V1_DREQ = 3'd2,
    MODE_V2_EVT  = 3'd3,
    MODE_ALL     = 3'd4
  } cap_mode_e;

  localparam logic [15:0] ETYPE_PTP   = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
  localparam logic [7:0]  PROTO_UDP   = 8'd17;
  localparam logic [15:0] EVT_PORT    = 16'd319;

  // byte offsets in an untagged frame, IPv4 without options
  localparam int OFS_ETYPE  = 12;
  localparam int OFS_L2_PTP = 14;
  localparam int OFS_PROTO  = 23;
  localparam int OFS_SPORT  = 34;
  localparam int OFS_DPORT  = 36;
  localparam int OFS_L4_PTP = 42;
  localparam int OFS_V1_CTL = OFS_L4_PTP + 32;

  localparam int MIN_L2  = OFS_L2_PTP + 1;
  localparam int MIN_UDP = OFS_DPORT + 2;
  localparam int MIN_V2  = OFS_L4_PTP + 1;
  localparam int MIN_V1  = OFS_V1_CTL + 1;

  typedef struct packed {
    logic [15:0] etype;
    logic [7:0]  proto;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [3:0]  l2_msg;
    logic [3:0]  l4_msg;
    logic [7:0]  v1_ctl;
  } hdr_t;
endpackage

// File: rtl/ptp_hdr_extract.sv
module ptp_hdr_extract
  import ptp_cls_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  input  logic             sof_i,
  output hdr_t             hdr_nxt_o,
  output logic [LEN_W-1:0] len_nxt_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  hdr_t             hdr_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx;
  int               pos;
  hdr_t             base;

  // including the current beat, so the last byte is usable on the eof beat
  always_comb begin
    idx  = (valid_i && sof_i) ? '0 : len_q;
    base = (valid_i && sof_i) ? '0 : hdr_q;
    pos  = 32'(idx);
    hdr_nxt_o = base;
    len_nxt_o = len_q;
    if (valid_i) begin
      len_nxt_o = (idx == LEN_MAX) ? LEN_MAX : idx + 1'b1;
      if (pos == OFS_ETYPE)      hdr_nxt_o.etype[15:8] = data_i;
      if (pos == OFS_ETYPE + 1)  hdr_nxt_o.etype[7:0]  = data_i;
      if (pos == OFS_L2_PTP)     hdr_nxt_o.l2_msg      = data_i[3:0];
      if (pos == OFS_PROTO)      hdr_nxt_o.proto       = data_i;
      if (pos == OFS_SPORT)      hdr_nxt_o.sport[15:8] = data_i;
      if (pos == OFS_SPORT + 1)  hdr_nxt_o.sport[7:0]  = data_i;
      if (pos == OFS_DPORT)      hdr_nxt_o.dport[15:8] = data_i;
      if (pos == OFS_DPORT + 1)  hdr_nxt_o.dport[7:0]  = data_i;
      if (pos == OFS_L4_PTP)     hdr_nxt_o.l4_msg      = data_i[3:0];
      if (pos == OFS_V1_CTL)     hdr_nxt_o.v1_ctl      = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
      len_q <= '0;
    end else begin
      hdr_q <= hdr_nxt_o;
      len_q <= len_nxt_o;
    end
  end

  AST_LEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && len_q != LEN_MAX) |=> (len_q == $past(len_q) + 1'b1)); // R10
  AST_SOF_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> (len_q == LEN_W'(1))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(len_q)); // R10
endmodule

// File: rtl/ptp_evt_match.sv
module ptp_evt_match
  import ptp_cls_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  hdr_t             hdr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [2:0]       mode_i,
  input  logic             src_chk_i,
  output logic             hit_o
);
  int   len;
  logic l2_hit, udp_hit, v2_l4_hit, v1_sync, v1_dreq;

  always_comb begin
    len       = 32'(len_i);
    l2_hit    = (len >= MIN_L2) && (hdr_i.etype == ETYPE_PTP) && (hdr_i.l2_msg < 4'd4);
    udp_hit   = (len >= MIN_UDP) && (hdr_i.etype == ETYPE_IPV4) && (hdr_i.proto == PROTO_UDP)
              && (hdr_i.dport == EVT_PORT) && (!src_chk_i || hdr_i.sport == EVT_PORT);
    v2_l4_hit = udp_hit && (len >= MIN_V2) && (hdr_i.l4_msg < 4'd4);
    v1_sync   = udp_hit && (len >= MIN_V1) && (hdr_i.v1_ctl == 8'd0);
    v1_dreq   = udp_hit && (len >= MIN_V1) && (hdr_i.v1_ctl == 8'd1);
    case (mode_i)
      MODE_V1_SYNC: hit_o = v1_sync;
      MODE_V1_DREQ: hit_o = v1_dreq;
      MODE_V2_EVT:  hit_o = l2_hit || v2_l4_hit;
      MODE_ALL:     hit_o = 1'b1;
      default:      hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
  import ptp_cls_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic [2:0] mode_i,
  input  logic       src_chk_i,
  output logic       capture_o
);
  hdr_t             hdr_nxt;
  logic [LEN_W-1:0] len_nxt;
  logic             hit;
  logic             cap_q;

  ptp_hdr_extract #(.LEN_W(LEN_W)) u_extract (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .valid_i   (valid_i),
    .sof_i     (sof_i),
    .hdr_nxt_o (hdr_nxt),
    .len_nxt_o (len_nxt)
  );

  ptp_evt_match #(.LEN_W(LEN_W)) u_match (
    .hdr_i     (hdr_nxt),
    .len_i     (len_nxt),
    .mode_i    (mode_i),
    .src_chk_i (src_chk_i),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= valid_i && eof_i && hit;
  end

  assign capture_o = cap_q;

  AST_CAP_ON_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> $past(valid_i && eof_i)); // R2
  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> !($past(mode_i) inside {3'd0, 3'd5, 3'd6, 3'd7})); // R3
  AST_ALL_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i && mode_i == MODE_ALL) |=> capture_o); // R4
  AST_SHORT_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i && mode_i != MODE_ALL && 32'(len_nxt) < MIN_L2) |=> !capture_o); // R9
endmodule

// File: tb/tb_ptp_evt_classifier.sv
`timescale 1ns/1ps
module tb_ptp_evt_classifier;
  typedef logic [7:0] bq_t[$];

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       sof_i = 1'b0;
  logic       eof_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic       src_chk_i = 1'b0;
  logic       capture_o;

  int    total = 0;
  int    bad = 0;
  string req = "R1";
  bit    exp_flag = 1'b0;
  bit    exp_d = 1'b0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ptp_evt_classifier dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .sof_i(sof_i), .eof_i(eof_i), .mode_i(mode_i), .src_chk_i(src_chk_i),
    .capture_o(capture_o)
  );

  function automatic bit ref_hit(bq_t f, int mode, bit schk);
    int n = f.size();
    int et, pr, sp, dp, m2, m4, ctl;
    bit udp;
    if (mode == 4) return 1'b1;
    et  = (n > 13) ? int'({f[12], f[13]}) : -1;
    m2  = (n > 14) ? int'(f[14] & 8'h0F) : -1;
    pr  = (n > 23) ? int'(f[23]) : -1;
    sp  = (n > 35) ? int'({f[34], f[35]}) : -1;
    dp  = (n > 37) ? int'({f[36], f[37]}) : -1;
    m4  = (n > 42) ? int'(f[42] & 8'h0F) : -1;
    ctl = (n > 74) ? int'(f[74]) : -1;
    udp = (et == 'h0800) && (pr == 17) && (dp == 319) && (!schk || sp == 319);
    case (mode)
      1: return udp && ctl == 0;
      2: return udp && ctl == 1;
      3: return (et == 'h88F7 && m2 >= 0 && m2 < 4) || (udp && m4 >= 0 && m4 < 4);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bq_t mk_l2(int n, logic [3:0] msg, logic [15:0] et);
    bq_t f;
    for (int i = 0; i < n; i++) f.push_back(8'(i * 7 + 3));
    if (n > 12) f[12] = et[15:8];
    if (n > 13) f[13] = et[7:0];
    if (n > 14) f[14] = {4'h2, msg};
    return f;
  endfunction

  function automatic bq_t mk_udp(int n, logic [15:0] sp, logic [15:0] dp, logic [7:0] pr,
                                 logic [3:0] msg, logic [7:0] ctl);
    bq_t f;
    for (int i = 0; i < n; i++) f.push_back(8'(i * 13 + 5));
    if (n > 13) begin f[12] = 8'h08; f[13] = 8'h00; end
    if (n > 14) f[14] = 8'h45;
    if (n > 23) f[23] = pr;
    if (n > 35) begin f[34] = sp[15:8]; f[35] = sp[7:0]; end
    if (n > 37) begin f[36] = dp[15:8]; f[37] = dp[7:0]; end
    if (n > 42) f[42] = {4'h0, msg};
    if (n > 74) f[74] = ctl;
    return f;
  endfunction

  // expected pulse lags the eof beat by one register
  always @(posedge clk_i) exp_d <= rst_ni && valid_i && eof_i && exp_flag;

  always @(negedge clk_i) begin
    if (mon_on && !done) begin
      total++;
      if (capture_o !== exp_d) begin
        bad++;
        $display("FAIL %s: capture_o=%0b expected=%0b at %0t", req, capture_o, exp_d, $time);
      end
    end
  end

  task automatic send(bq_t f, int gap);
    for (int i = 0; i < f.size(); i++) begin
      @(negedge clk_i);
      data_i   = f[i];
      valid_i  = 1'b1;
      sof_i    = (i == 0);
      eof_i    = (i == f.size() - 1);
      exp_flag = eof_i ? ref_hit(f, int'(mode_i), src_chk_i) : 1'b0;
      if (gap > 0 && (i % gap) == gap - 1 && !eof_i) begin
        @(negedge clk_i);
        valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; data_i = 8'hEE;
      end
    end
  endtask

  task automatic send_head(bq_t f, int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk_i);
      data_i = f[i]; valid_i = 1'b1; sof_i = (i == 0); eof_i = 1'b0; exp_flag = 1'b0;
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; exp_flag = 1'b0;
    end
  endtask

  task automatic set_mode(int m, bit s, string r);
    @(negedge clk_i);
    valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
    mode_i = 3'(m); src_chk_i = s; req = r;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    total++;
    if (capture_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: capture_o=%0b expected=0 during reset", capture_o);
    end
    rst_ni = 1'b1;
    mon_on = 1'b1;
    idle(4);

    set_mode(4, 0, "R4");
    send(mk_l2(1, 4'h9, 16'h1234), 0);
    idle(1);
    send(mk_l2(60, 4'h9, 16'h1234), 0);
    send(mk_udp(30, 16'd5, 16'd6, 8'd6, 4'h0, 8'h0), 0);
    idle(3);

    set_mode(0, 0, "R3");
    send(mk_l2(60, 4'h0, 16'h88F7), 0);
    send(mk_udp(90, 16'd319, 16'd319, 8'd17, 4'h0, 8'h0), 0);
    set_mode(6, 0, "R3");
    send(mk_l2(60, 4'h1, 16'h88F7), 0);
    set_mode(7, 0, "R3");
    send(mk_udp(90, 16'd319, 16'd319, 8'd17, 4'h1, 8'h0), 0);
    idle(2);

    set_mode(3, 0, "R5");
    send(mk_l2(60, 4'h0, 16'h88F7), 0);
    idle(1);
    send(mk_l2(60, 4'h3, 16'h88F7), 2);
    send(mk_l2(60, 4'h8, 16'h88F7), 0);
    send(mk_l2(60, 4'h4, 16'h88F7), 0);
    send(mk_l2(60, 4'h0, 16'h88F5), 0);
    idle(2);

    req = "R6";
    send(mk_udp(64, 16'd1000, 16'd319, 8'd17, 4'h1, 8'h0), 0);
    send(mk_udp(64, 16'd1000, 16'd320, 8'd17, 4'h1, 8'h0), 0);
    send(mk_udp(64, 16'd1000, 16'd319, 8'd6, 4'h1, 8'h0), 3);
    send(mk_udp(64, 16'd1000, 16'd319, 8'd17, 4'hB, 8'h0), 0);
    send(mk_udp(64, 16'd1000, 16'h3F01, 8'd17, 4'h1, 8'h0), 0);
    idle(2);

    set_mode(3, 1, "R7");
    send(mk_udp(64, 16'd319, 16'd319, 8'd17, 4'h2, 8'h0), 0);
    send(mk_udp(64, 16'd1000, 16'd319, 8'd17, 4'h2, 8'h0), 0);
    set_mode(3, 0, "R7");
    send(mk_udp(64, 16'd1000, 16'd319, 8'd17, 4'h2, 8'h0), 0);
    idle(2);

    set_mode(1, 0, "R8");
    send(mk_udp(90, 16'd319, 16'd319, 8'd17, 4'h0, 8'h00), 0);
    send(mk_udp(90, 16'd319, 16'd319, 8'd17, 4'h0, 8'h01), 0);
    send(mk_l2(90, 4'h0, 16'h88F7), 0);
    set_mode(2, 0, "R8");
    send(mk_udp(90, 16'd319, 16'd319, 8'd17, 4'h0, 8'h01), 4);
    send(mk_udp(90, 16'd319, 16'd319, 8'd17, 4'h0, 8'h00), 0);
    send(mk_udp(90, 16'd319, 16'd320, 8'd17, 4'h0, 8'h01), 0);
    idle(2);

    set_mode(3, 0, "R9");
    send(mk_l2(14, 4'h0, 16'h88F7), 0);
    send(mk_l2(15, 4'h0, 16'h88F7), 0);
    send(mk_udp(42, 16'd319, 16'd319, 8'd17, 4'h0, 8'h0), 0);
    send(mk_udp(43, 16'd319, 16'd319, 8'd17, 4'h0, 8'h0), 0);
    set_mode(1, 0, "R9");
    send(mk_udp(74, 16'd319, 16'd319, 8'd17, 4'h0, 8'h0), 0);
    send(mk_udp(75, 16'd319, 16'd319, 8'd17, 4'h0, 8'h0), 0);
    idle(2);

    set_mode(3, 0, "R10");
    send_head(mk_l2(60, 4'h0, 16'h88F7), 20);
    send(mk_l2(60, 4'h0, 16'h1111), 0);
    send_head(mk_udp(64, 16'd319, 16'd319, 8'd17, 4'h0, 8'h0), 50);
    send(mk_l2(10, 4'h0, 16'h0000), 0);
    send(mk_l2(30, 4'h1, 16'h88F7), 1);
    send(mk_l2(300, 4'h2, 16'h88F7), 0);
    send(mk_l2(300, 4'h9, 16'h88F7), 0);
    idle(4);

    set_mode(3, 0, "R2");
    for (int k = 0; k < 6; k++) send(mk_l2(20 + k, 4'(k), 16'h88F7), 0);
    idle(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule